// File: doc/BRIEF.md
# Vector length configuration unit

This unit owns a 32-bit vector state word that belongs to prefixed instructions. When a 64-bit prefixed instruction carries a nonzero 12-bit length-type field, the unit decodes it and updates the current length (VL) and the maximum length (MAXVL) of that word. Depending on the mode, the new length comes from an immediate, from a scalar register, or from the old length clamped to a newly set maximum. Every accepted update also asks for the resulting VL to be written into a destination scalar register.

A zero length-type field means the instruction uses the global vector state, and this unit does nothing. Encodings that cannot be honoured raise a one-cycle illegal-instruction flag and leave everything untouched. Such encodings include naming x0 as the length source, an immediate limit wider than the scalar word, and any override on a build without override support. A CSR-style port lets software save the word and restore it. The four reserved top bits always read as zero, and writing a one to any of them raises the flag.

Top module: `vlc_top`

## Requirements
- R1: After reset the state word is zero and neither the write-back pulse nor the illegal flag is high.
- R2: A valid strobe with the length-type field equal to zero changes no state and produces neither a write-back nor an illegal flag.
- R3: Register-or-immediate mode with bit 11 = 0 and bit 0 = 0: VL becomes bits[5:1] + 1, and MAXVL is unchanged.
- R4: Register mode with bit 11 = 0 and bit 0 = 1: the read index output equals bits[5:1], and VL becomes min(register value, current MAXVL). If bits[5:1] are zero, the instruction is illegal.
- R5: Bit 11 = 1 and bit 0 = 0: both MAXVL and VL become bits[5:1] + 1.
- R6: Bit 11 = 1 and bit 0 = 1: MAXVL becomes bits[5:1] + 1, and VL becomes min(old VL, new MAXVL).
- R7: An accepted update raises the write-back pulse for exactly the one cycle after the strobe. Its index is bits[10:6] and its data is the new VL, zero-extended. No pulse is raised when bits[10:6] are zero.
- R8: State layout: MAXVL [5:0], VL [11:6], source offset [17:12], destination offset [23:18], sub-vector length [25:24], sub-vector offset [27:26], reserved [31:28]. An accepted update clears both offsets and keeps bits [27:24].
- R9: In the three immediate modes, an immediate limit bits[5:1] + 1 greater than XLEN is illegal.
- R10: A CSR write stores bits [27:0] in the cycle after it is asserted, and the reserved bits read as zero. A write with any reserved bit set raises the illegal flag for one cycle.
- R11: With override support disabled, any nonzero length-type field is illegal and a zero field is not.
- R12: An illegal instruction changes no state and produces no write-back. The illegal flag is a one-cycle pulse in the cycle after the strobe.
- R13: If a valid strobe and a CSR write arrive in the same cycle, the CSR write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | Length-type field is valid this cycle |
| lenType | input | 12 | Length-type field from the prefix |
| srcIdx | output | 5 | Scalar register read index (bits [5:1] of the field) |
| srcVal | input | XLEN | Value read from the scalar register at srcIdx |
| csrWe | input | 1 | Software write of the state word |
| csrWdata | input | 32 | Value for the software write |
| csrRdata | output | 32 | Current state word |
| wbValid | output | 1 | One-cycle write-back request |
| wbIdx | output | 5 | Destination scalar register for write-back |
| wbData | output | XLEN | New VL, zero-extended |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
The hardest case to reach is the clamping mode with a non-trivial old length. The state has to be driven to a VL larger than the new maximum, with nonzero offsets and sub-vector bits, before the clamp instruction arrives. The stimulus gets there by first setting VL through the one-off mode and then loading the offsets through the CSR port. The immediate-limit trap only shows up when XLEN is smaller than 32, so the bench builds the unit with XLEN of 16 and tries limits of 16 and 21. It also builds a second copy with override support disabled and drives the same inputs into it.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int FW      = 6;
  localparam int MAX_LSB = 0;
  localparam int VL_LSB  = 6;
  localparam int SRC_LSB = 12;
  localparam int DST_LSB = 18;
  localparam int RSV_LSB = 28;
  localparam int STW     = 32;
  localparam logic [STW-1:0] IMPL_MASK = {{(STW-RSV_LSB){1'b0}}, {RSV_LSB{1'b1}}};

  typedef enum logic [1:0] {
    VL_IMM   = 2'd0,
    VL_REG   = 2'd1,
    VL_CLAMP = 2'd2
  } vlSel_e;

  typedef struct packed {
    logic   ldVl;
    logic   ldMax;
    logic   ldCsr;
    logic   wbEn;
    logic   flag;
    vlSel_e vlSel;
  } ctlStrb_t;
endpackage

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_OVR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgValid,
  input  logic [11:0] lenType,
  input  logic        csrWe,
  input  logic        csrRsvNz,
  output ctlStrb_t    strb
);
  logic [4:0] imm;
  logic       oneOff;
  logic       regMode;
  logic       immBig;
  logic       bad;
  logic       take;

  assign imm     = lenType[5:1];
  assign oneOff  = lenType[11];
  assign regMode = !oneOff && lenType[0];
  assign immBig  = (int'(imm) + 1) > XLEN;

  always_comb begin
    bad = 1'b0;
    if (!HAS_OVR)          bad = 1'b1;
    else if (regMode)      bad = (imm == 5'd0);
    else                   bad = immBig;
  end

  assign take = cfgValid && (lenType != 12'd0) && !bad;

  always_comb begin
    strb       = '0;
    strb.ldVl  = take;
    strb.ldMax = take && oneOff;
    strb.wbEn  = take && (lenType[10:6] != 5'd0);
    strb.ldCsr = csrWe && !cfgValid;
    strb.flag  = (cfgValid && (lenType != 12'd0) && bad) || (csrWe && !cfgValid && csrRsvNz);
    if (!oneOff) strb.vlSel = regMode ? VL_REG : VL_IMM;
    else         strb.vlSel = lenType[0] ? VL_CLAMP : VL_IMM;
  end

  // R4: x0 as length source never loads VL
  a_r4_x0_src_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgValid && lenType[11] == 1'b0 && lenType[5:0] == 6'd1) |-> (!strb.ldVl && strb.flag));
  // R12: flag and load never together
  a_r12_flag_excl_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flag |-> !strb.ldVl);
endmodule

// File: rtl/vlc_dp.sv
module vlc_dp
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctlStrb_t        strb,
  input  logic [4:0]      imm,
  input  logic [4:0]      dstIdx,
  input  logic [XLEN-1:0] srcVal,
  input  logic [STW-1:0]  csrWdata,
  output logic [STW-1:0]  state,
  output logic            wbValid,
  output logic [4:0]      wbIdx,
  output logic [XLEN-1:0] wbData,
  output logic            illegal
);
  logic [FW-1:0] curMax, curVl, immP1, regMin, clampVl, nextVl, nextMax;

  assign curMax  = state[MAX_LSB +: FW];
  assign curVl   = state[VL_LSB +: FW];
  assign immP1   = {1'b0, imm} + FW'(1);
  assign regMin  = (srcVal > XLEN'(curMax)) ? curMax : srcVal[FW-1:0];
  assign clampVl = (curVl > immP1) ? immP1 : curVl;
  assign nextMax = strb.ldMax ? immP1 : curMax;

  always_comb begin
    case (strb.vlSel)
      VL_REG:   nextVl = regMin;
      VL_CLAMP: nextVl = clampVl;
      default:  nextVl = immP1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= '0;
      wbValid <= 1'b0;
      wbIdx   <= '0;
      wbData  <= '0;
      illegal <= 1'b0;
    end else begin
      if (strb.ldCsr) begin
        state <= csrWdata & IMPL_MASK;
      end else if (strb.ldVl) begin
        state[MAX_LSB +: FW] <= nextMax;
        state[VL_LSB +: FW]  <= nextVl;
        state[SRC_LSB +: FW] <= '0;
        state[DST_LSB +: FW] <= '0;
      end
      wbValid <= strb.wbEn;
      wbIdx   <= dstIdx;
      wbData  <= XLEN'(nextVl);
      illegal <= strb.flag;
    end
  end

  // R10: reserved bits never set
  a_r10_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state[STW-1:RSV_LSB] == '0);
  // R7: write-back value equals stored length
  a_r7_wb_matches_vl: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (wbData == XLEN'(state[VL_LSB +: FW])));
  // R12: no write-back with an illegal flag
  a_r12_no_wb_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wbValid);
  // R6: clamp mode never leaves VL above MAXVL
  a_r6_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ldVl && strb.vlSel == VL_CLAMP) |=> (state[VL_LSB +: FW] <= state[MAX_LSB +: FW]));
  // R8: offsets zero after an update
  a_r8_offs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ldVl && !strb.ldCsr) |=> (state[SRC_LSB +: FW] == '0 && state[DST_LSB +: FW] == '0));
endmodule

// File: rtl/vlc_top.sv
module vlc_top
  import vlc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_OVR = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgValid,
  input  logic [11:0]     lenType,
  output logic [4:0]      srcIdx,
  input  logic [XLEN-1:0] srcVal,
  input  logic            csrWe,
  input  logic [31:0]     csrWdata,
  output logic [31:0]     csrRdata,
  output logic            wbValid,
  output logic [4:0]      wbIdx,
  output logic [XLEN-1:0] wbData,
  output logic            illegal
);
  ctlStrb_t strb;

  assign srcIdx = lenType[5:1];

  vlc_ctrl #(.XLEN(XLEN), .HAS_OVR(HAS_OVR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgValid (cfgValid),
    .lenType  (lenType),
    .csrWe    (csrWe),
    .csrRsvNz (csrWdata[STW-1:RSV_LSB] != '0),
    .strb     (strb)
  );

  vlc_dp #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .imm      (lenType[5:1]),
    .dstIdx   (lenType[10:6]),
    .srcVal   (srcVal),
    .csrWdata (csrWdata),
    .state    (csrRdata),
    .wbValid  (wbValid),
    .wbIdx    (wbIdx),
    .wbData   (wbData),
    .illegal  (illegal)
  );
endmodule

// File: tb/sim_vlc_top.sv
module sim_vlc_top;
  localparam int XL = 16;
  localparam time HALF = 2.5ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgValid = 1'b0;
  logic [11:0] lenType = '0;
  logic [XL-1:0] srcVal = '0;
  logic csrWe = 1'b0;
  logic [31:0] csrWdata = '0;
  logic [4:0] srcIdx, wbIdx, srcIdx1, wbIdx1;
  logic [31:0] rd0, rd1;
  logic wbV0, ill0, wbV1, ill1;
  logic [XL-1:0] wbD0, wbD1;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [31:0] mSt0 = '0, mSt1 = '0;
  bit mWb = 0, mIll0 = 0, mIll1 = 0;
  int mIdx = 0, mData = 0;

  always #HALF clk = ~clk;

  vlc_top #(.XLEN(XL), .HAS_OVR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .lenType(lenType),
    .srcIdx(srcIdx), .srcVal(srcVal), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(rd0), .wbValid(wbV0), .wbIdx(wbIdx), .wbData(wbD0), .illegal(ill0));

  vlc_top #(.XLEN(XL), .HAS_OVR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .lenType(lenType),
    .srcIdx(srcIdx1), .srcVal(srcVal), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(rd1), .wbValid(wbV1), .wbIdx(wbIdx1), .wbData(wbD1), .illegal(ill1));

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit ovr, input logic [31:0] st, output logic [31:0] nst,
                       output bit wb, output int idx, output int dat, output bit ill);
    int imm, mx, vl, nmx, nvl;
    bit regMode, bad;
    nst = st; wb = 0; idx = 0; dat = 0; ill = 0;
    if (cfgValid) begin
      if (lenType != 0) begin
        imm = int'(lenType[5:1]);
        mx = int'(st[5:0]);
        vl = int'(st[11:6]);
        regMode = !lenType[11] && lenType[0];
        if (!ovr) bad = 1;
        else if (regMode) bad = (imm == 0);
        else bad = (imm + 1 > XL);
        if (bad) ill = 1;
        else begin
          nmx = mx;
          if (!lenType[11]) nvl = regMode ? ((int'(srcVal) > mx) ? mx : int'(srcVal)) : imm + 1;
          else begin
            nmx = imm + 1;
            nvl = lenType[0] ? ((vl > nmx) ? nmx : vl) : nmx;
          end
          nst[5:0] = nmx[5:0];
          nst[11:6] = nvl[5:0];
          nst[23:12] = '0;
          idx = int'(lenType[10:6]);
          wb = (idx != 0);
          dat = nvl;
        end
      end
    end else if (csrWe) begin
      nst = csrWdata & 32'h0FFF_FFFF;
      ill = (csrWdata[31:28] != 0);
    end
  endtask

  // Drive inputs at the negedge, advance one clock, compare at the next negedge.
  task automatic step(input string tag, input bit v, input logic [11:0] lt,
                      input int src, input bit we, input logic [31:0] wd);
    logic [31:0] n0, n1;
    bit w0, i0, w1, i1;
    int x0, d0, x1, d1;
    cfgValid = v; lenType = lt; srcVal = XL'(src); csrWe = we; csrWdata = wd;
    #1;
    cmp(tag, "srcIdx", int'(srcIdx), int'(lt[5:1]));
    model(1'b1, mSt0, n0, w0, x0, d0, i0);
    model(1'b0, mSt1, n1, w1, x1, d1, i1);
    @(posedge clk);
    @(negedge clk);
    cfgValid = 0; csrWe = 0;
    mSt0 = n0; mWb = w0; mIdx = x0; mData = d0; mIll0 = i0;
    mSt1 = n1; mIll1 = i1;
    cmp(tag, "state", int'(rd0), int'(mSt0));
    cmp(tag, "wbValid", int'(wbV0), int'(mWb));
    if (mWb) begin
      cmp(tag, "wbIdx", int'(wbIdx), mIdx);
      cmp(tag, "wbData", int'(wbD0), mData);
    end
    cmp(tag, "illegal", int'(ill0), int'(mIll0));
    cmp({tag, "/R11"}, "state_noovr", int'(rd1), int'(mSt1));
    cmp({tag, "/R11"}, "illegal_noovr", int'(ill1), int'(mIll1));
    cmp({tag, "/R11"}, "wb_noovr", int'(wbV1), 0);
  endtask

  function automatic logic [11:0] lt(input bit b11, input int dst, input int imm, input bit b0);
    return {b11, dst[4:0], imm[4:0], b0};
  endfunction

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "state", int'(rd0), 0);
    cmp("R1", "wbValid", int'(wbV0), 0);
    cmp("R1", "illegal", int'(ill0), 0);
    rst_n = 1;
    @(negedge clk);
    step("R2", 1, 12'd0, 0, 0, 0);
    step("R3_R7", 1, lt(0, 3, 4, 0), 0, 0, 0);       // VL=5, wb x3
    step("R7_idle", 0, 12'd0, 0, 0, 0);               // pulse drops
    step("R5_R7", 1, lt(1, 0, 9, 0), 0, 0, 0);        // MAXVL=VL=10, no wb (x0)
    step("R10", 0, 12'd0, 0, 1, 32'h0B1C_528A);       // offsets, subvl, maxvl 10 vl 10
    step("R6_R8", 1, lt(1, 7, 3, 1), 0, 0, 0);        // MAXVL=4 VL=4, offs cleared
    step("R6", 1, lt(1, 9, 12, 1), 0, 0, 0);          // MAXVL=13 VL stays 4
    step("R4", 1, lt(0, 2, 5, 1), 2, 0, 0);           // VL=min(2,13)
    step("R4_big", 1, lt(0, 31, 5, 1), 100, 0, 0);    // VL=13
    step("R4_x0_R12", 1, lt(0, 4, 0, 1), 3, 0, 0);    // illegal
    step("R9_over", 1, lt(0, 6, 20, 0), 0, 0, 0);     // 21 > 16 illegal
    step("R9_C_over", 1, lt(1, 6, 16, 0), 0, 0, 0);   // 17 > 16 illegal
    step("R9_edge", 1, lt(1, 6, 15, 0), 0, 0, 0);     // 16 legal
    step("R10_rsv", 0, 12'd0, 0, 1, 32'hF000_0041);
    step("R13", 1, lt(0, 1, 2, 0), 0, 1, 32'h0000_0FFF);
    step("R11_zero", 1, 12'd0, 0, 0, 0);
    step("R6_deep", 0, 12'd0, 0, 1, 32'h0FFF_F7DF);   // VL 31, MAXVL 31
    step("R6_clampdown", 1, lt(1, 30, 1, 1), 0, 0, 0);// MAXVL=2 VL=2
    step("R3_keepmax", 1, lt(0, 8, 13, 0), 0, 0, 0);  // VL=14, MAXVL 2
    step("R2_again", 1, 12'd0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule